// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Interrupt Detection

This block drives and samples sixteen general-purpose pins through a small memory-mapped register port that carries 16-bit words. Software picks the direction of each pin and changes the output latch through separate set and clear strobes, so it never needs a read-modify-write. It reads back the synchronized input levels. The block does not contain pad drivers or tri-state buffers. It only presents a per-pin output-enable and an output value.

Each pin can be made level-sensitive or edge-sensitive. A level-sensitive pin is active on either a high or a low level. An edge-sensitive pin has its own rising and falling detectors, and both can be enabled at once. A pending pin reaches the single interrupt line only when its mask bit is clear and its enable bit is set. Software reads the gated pending state from a status register and acknowledges edge events by writing ones to a clear register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the mask register (0x28) reads 0xFFFF. Direction, output latch, level select, polarity, rising enable, falling enable and enable all read 0. Nothing is pending, `irq` is 0 and `pin_oe`/`pin_out` are 0.
- R2: A 1 in direction register bit n (0x00) drives `pin_oe[n]` high, and a 0 makes pin n an input. The register reads back what was written, and `pin_oe` changes only on a write to 0x00.
- R3: A write to 0x18 sets every latch bit that is 1 in the word, and a write to 0x1C clears every latch bit that is 1. Zero bits leave the latch as it was. `pin_out` shows the latch, and 0x20 reads it back.
- R4: A read of 0x14 returns `pin_in` after a two-flop synchronizer. Read data appears on `rdata` in the cycle after the clock edge that samples `rd_en`.
- R5: A 1 in level-select bit n (0x04) makes pin n level-sensitive. Polarity bit n (0x08) set to 1 selects an active-high level, and 0 selects an active-low level. A level-sensitive pending bit follows the active level.
- R6: When level-select bit n is 0, pin n is edge-sensitive. Rising enable (0x0C) detects 0-to-1 changes, and falling enable (0x10) detects 1-to-0 changes. With both set, either edge is detected. An edge is found by comparing the synchronized value with its value one clock earlier.
- R7: Status register 0x30 returns the pending bits whose mask bit is 0 and whose enable bit (0x2C) is 1. `irq` is the OR of those bits.
- R8: Writing ones to 0x34 clears the matching edge-sensitive pending bits. Zero bits have no effect. An edge pending bit stays set until it is cleared.
- R9: A clear written to a level-sensitive pin whose level is still active leaves it pending.
- R10: When a clear and a new edge on the same pin fall in the same cycle, the pin stays pending.
- R11: Reads of 0x18, 0x1C, 0x34 and of any unmapped offset return 0. `rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after the read strobe |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_oe | output | 16 | Per-pin output enable |
| pin_out | output | 16 | Per-pin output value |
| irq | output | 1 | Combined interrupt request |

## Verification
Acknowledging an edge and detecting a fresh edge on the same pin can happen in the same clock cycle. The bench provokes this by counting the synchronizer stages, so that the clear write lands on exactly the edge where the new transition registers. It then judges the result by reading the status register, which must still show the pin pending, and confirms that a later plain clear does empty it. Level pins are checked the same way: a clear written while the level is held must leave the bit set. Random rounds mix every trigger mode with random mask and enable words and compare the status against a bench function built from the requirements.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 16,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out,
  output logic             irq
);

  localparam logic [AW-1:0] A_DIR  = AW'('h00);
  localparam logic [AW-1:0] A_LVL  = AW'('h04);
  localparam logic [AW-1:0] A_POL  = AW'('h08);
  localparam logic [AW-1:0] A_RISE = AW'('h0C);
  localparam logic [AW-1:0] A_FALL = AW'('h10);
  localparam logic [AW-1:0] A_DIN  = AW'('h14);
  localparam logic [AW-1:0] A_SET  = AW'('h18);
  localparam logic [AW-1:0] A_CLR  = AW'('h1C);
  localparam logic [AW-1:0] A_DOUT = AW'('h20);
  localparam logic [AW-1:0] A_MSK  = AW'('h28);
  localparam logic [AW-1:0] A_ENA  = AW'('h2C);
  localparam logic [AW-1:0] A_STAT = AW'('h30);
  localparam logic [AW-1:0] A_ACK  = AW'('h34);
  localparam logic [NPINS-1:0] ALL1 = {NPINS{1'b1}};

  logic [NPINS-1:0] dir_q, lvl_q, pol_q, rise_q, fall_q, out_q, msk_q, ena_q;
  logic [NPINS-1:0] meta_q, sync_q, prev_q, pend_q;
  logic [NPINS-1:0] ack_vec, lvl_hit, edge_hit, stat, rmux;

  wire wr_dir  = wr_en && addr == A_DIR;
  wire wr_lvl  = wr_en && addr == A_LVL;
  wire wr_pol  = wr_en && addr == A_POL;
  wire wr_rise = wr_en && addr == A_RISE;
  wire wr_fall = wr_en && addr == A_FALL;
  wire wr_set  = wr_en && addr == A_SET;
  wire wr_clr  = wr_en && addr == A_CLR;
  wire wr_msk  = wr_en && addr == A_MSK;
  wire wr_ena  = wr_en && addr == A_ENA;

  assign ack_vec  = (wr_en && addr == A_ACK) ? wdata : '0;
  assign lvl_hit  = lvl_q & ~(sync_q ^ pol_q);
  assign edge_hit = ~lvl_q & ((rise_q & sync_q & ~prev_q) | (fall_q & ~sync_q & prev_q));
  assign stat     = pend_q & ~msk_q & ena_q;
  assign irq      = |stat;
  assign pin_oe   = dir_q;
  assign pin_out  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lvl_q  <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
      msk_q  <= ALL1;
      ena_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_lvl)  lvl_q  <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      if (wr_rise) rise_q <= wdata;
      if (wr_fall) fall_q <= wdata;
      if (wr_msk)  msk_q  <= wdata;
      if (wr_ena)  ena_q  <= wdata;
      if (wr_set)  out_q  <= out_q | wdata;
      else if (wr_clr) out_q <= out_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      pend_q <= lvl_hit | (~lvl_q & ((pend_q & ~ack_vec) | edge_hit));
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rmux = dir_q;
      A_LVL:   rmux = lvl_q;
      A_POL:   rmux = pol_q;
      A_RISE:  rmux = rise_q;
      A_FALL:  rmux = fall_q;
      A_DIN:   rmux = sync_q;
      A_DOUT:  rmux = out_q;
      A_MSK:   rmux = msk_q;
      A_ENA:   rmux = ena_q;
      A_STAT:  rmux = stat;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rmux : '0;
  end

  // R3
  out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(wdata)) == $past(wdata)));

  // R3
  out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((pin_out & $past(wdata)) == '0));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R8
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(lvl_q) & ~$past(ack_vec) & ~pend_q) == '0));

  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_SET || addr == A_CLR || addr == A_ACK)) |=> rdata == '0);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0, pin_in = '0;
  logic [15:0] rdata, pin_oe, pin_out;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_pend(input logic [15:0] o, input logic [15:0] n,
      input logic [15:0] lv, input logic [15:0] pl, input logic [15:0] ri, input logic [15:0] fa);
    logic [15:0] lvl_act, edg;
    lvl_act = lv & ~(n ^ pl);
    edg = ~lv & ((ri & n & ~o) | (fa & o & ~n));
    return lvl_act | edg;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, exp_out, old_in;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 pin_oe", pin_oe, 16'h0);
    chk("R1 pin_out", pin_out, 16'h0);
    rd(6'h28, v); chk("R1 mask", v, 16'hFFFF);
    foreach (u_dummy_offsets[i]) begin
      rd(u_dummy_offsets[i], v); chk("R1 zero reg", v, 16'h0);
    end

    // R2 direction
    wr(6'h00, 16'hA5C3); chk("R2 pin_oe", pin_oe, 16'hA5C3);
    rd(6'h00, v); chk("R2 readback", v, 16'hA5C3);
    idle(2); chk("R2 hold", pin_oe, 16'hA5C3);

    // R3 set/clear latch
    wr(6'h18, 16'h00F0); chk("R3 set", pin_out, 16'h00F0);
    wr(6'h1C, 16'h0030); chk("R3 clr", pin_out, 16'h00C0);
    wr(6'h18, 16'h0000); chk("R3 set zeros", pin_out, 16'h00C0);
    wr(6'h1C, 16'h0000); chk("R3 clr zeros", pin_out, 16'h00C0);
    exp_out = 16'h00C0;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      if ($urandom % 2) begin wr(6'h18, d); exp_out |= d; end
      else begin wr(6'h1C, d); exp_out &= ~d; end
      chk("R3 random latch", pin_out, exp_out);
    end
    rd(6'h20, v); chk("R3 dout read", v, exp_out);

    // R11 write-only and unmapped reads
    rd(6'h18, v); chk("R11 set reads 0", v, 16'h0);
    rd(6'h1C, v); chk("R11 clr reads 0", v, 16'h0);
    rd(6'h34, v); chk("R11 ack reads 0", v, 16'h0);
    rd(6'h24, v); chk("R11 unmapped 24", v, 16'h0);
    rd(6'h3C, v); chk("R11 unmapped 3C", v, 16'h0);
    idle(1); chk("R11 idle rdata", rdata, 16'h0);

    // R4 input sampling
    pin_in = 16'h3C5A; idle(4);
    rd(6'h14, v); chk("R4 din", v, 16'h3C5A);
    pin_in = 16'h0000; idle(4);

    // R5 + R7 + R9 level pin 5 active high, mask/enable combos
    wr(6'h04, 16'h0020); wr(6'h08, 16'h0020);
    wr(6'h28, 16'h0000); wr(6'h2C, 16'h0000);
    pin_in = 16'h0020; idle(4);
    rd(6'h30, v); chk("R7 enable off", v, 16'h0);
    wr(6'h28, 16'h0020); wr(6'h2C, 16'h0020);
    rd(6'h30, v); chk("R7 masked", v, 16'h0);
    chk("R7 irq masked", {15'd0, irq}, 16'h0);
    wr(6'h28, 16'h0000);
    rd(6'h30, v); chk("R5 level high", v, 16'h0020);
    chk("R7 irq on", {15'd0, irq}, 16'h1);
    wr(6'h34, 16'h0020);
    rd(6'h30, v); chk("R9 level clear no effect", v, 16'h0020);
    pin_in = 16'h0000; idle(4);
    rd(6'h30, v); chk("R5 level gone", v, 16'h0);
    wr(6'h08, 16'h0000); idle(1);
    rd(6'h30, v); chk("R5 active low", v, 16'h0020);
    wr(6'h04, 16'h0000); wr(6'h08, 16'h0000); wr(6'h34, 16'hFFFF);

    // R6 + R8 edges on pin 3
    wr(6'h0C, 16'h0008); wr(6'h10, 16'h0008); wr(6'h2C, 16'hFFFF);
    pin_in = 16'h0008; idle(4);
    rd(6'h30, v); chk("R6 rising", v, 16'h0008);
    wr(6'h34, 16'h0000);
    rd(6'h30, v); chk("R8 zero ack keeps", v, 16'h0008);
    idle(3); rd(6'h30, v); chk("R8 sticky", v, 16'h0008);
    wr(6'h34, 16'h0008);
    rd(6'h30, v); chk("R8 cleared", v, 16'h0);
    pin_in = 16'h0000; idle(4);
    rd(6'h30, v); chk("R6 falling", v, 16'h0008);
    wr(6'h34, 16'h0008);

    // R10 clear and rising edge in the same cycle
    @(negedge clk); pin_in = 16'h0008;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 6'h34; wdata = 16'h0008;
    @(negedge clk); wr_en = 1'b0;
    idle(2);
    rd(6'h30, v); chk("R10 edge wins", v, 16'h0008);
    wr(6'h34, 16'h0008);
    rd(6'h30, v); chk("R10 later clear", v, 16'h0);

    // random modes
    old_in = pin_in;
    for (int it = 0; it < 60; it++) begin
      logic [15:0] lv, pl, ri, fa, mk, en, nw, e;
      lv = 16'($urandom); pl = 16'($urandom); ri = 16'($urandom);
      fa = 16'($urandom); mk = 16'($urandom); en = 16'($urandom);
      nw = 16'($urandom);
      wr(6'h04, lv); wr(6'h08, pl); wr(6'h0C, ri); wr(6'h10, fa);
      wr(6'h28, mk); wr(6'h2C, en); wr(6'h34, 16'hFFFF);
      @(negedge clk); pin_in = nw; idle(4);
      e = exp_pend(old_in, nw, lv, pl, ri, fa) & ~mk & en;
      chk("R7 random irq", {15'd0, irq}, {15'd0, |e});
      rd(6'h30, v); chk("R6 random status", v, e);
      rd(6'h14, v); chk("R4 random din", v, nw);
      old_in = nw;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [5:0] u_dummy_offsets [7] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h20, 6'h2C};
endmodule